// File: doc/BRIEF.md
# Dual Write-Posting Buffer

This block sits between a processor's store port and a memory controller. The processor hands it single 32-bit word writes, each with byte enables. The block posts each write into one of two small buffers, so the processor keeps running instead of waiting on memory. Each buffer holds up to four words. A run of consecutive word addresses fills one buffer, and that buffer is later sent to memory as a single burst with ascending addresses.

When a write does not continue the current run, filling moves to the second buffer at once. The first buffer is then queued for memory. A buffer is also queued when it reaches the last word of its aligned four-word group, or when no write has arrived for a set number of cycles. Memory receives the queued buffers in the order they were closed, so stores reach memory in program order. The processor stalls only when both buffers hold data that has not yet gone out.

Each memory-side beat carries the burst start address, the burst length, one data word, its byte enables and a last-beat flag. The memory controller accepts each beat with a ready signal.

Top module: `wpost_dual`

## Requirements
- R1: After reset, `cpu_ready` is 1 and `mem_valid` is 0.
- R2: Accepted writes to consecutive word addresses inside one aligned 4-word group form one burst. `mem_start` is the first word address of the run and `mem_len` is the number of words (1 to 4). The beats carry the words and byte enables in ascending address order.
- R3: A write whose word address has low two bits equal to 3 closes its buffer. That burst is offered on `mem_valid` in the cycle after the write is accepted, provided the memory side is idle. A following write to the next address starts a new burst.
- R4: A write whose address differs from the filling buffer's start plus its count closes the filling buffer and is placed in the other buffer. A repeat of the previous address counts as such a write.
- R5: While one buffer waits for memory or is being drained, the other buffer accepts writes with `cpu_ready` high.
- R6: `cpu_ready` is 0 only when both buffers hold data. The refused write completes, unchanged, once a buffer drains.
- R7: Bursts reach memory in the order their buffers were closed, which matches the order of the writes.
- R8: A partly filled buffer that receives no write for IDLE_CYC cycles is closed. With the memory side idle, `mem_valid` rises exactly IDLE_CYC cycles after the last accepted write (8 cycles by default).
- R9: While `mem_valid` is high and `mem_ready` is low, every memory-side output holds its value. `mem_start` and `mem_len` stay constant across all beats of a burst, and `mem_last` marks its final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor presents a write |
| cpu_addr | input | AW | Word address of the write |
| cpu_wdata | input | DW | Write data |
| cpu_be | input | DW/8 | Byte enables of the write |
| cpu_ready | output | 1 | Write is accepted on this edge when high with cpu_valid |
| mem_valid | output | 1 | A burst beat is offered |
| mem_start | output | AW | Word address of the burst's first beat |
| mem_len | output | $clog2(BUF_WORDS+1) | Number of beats in the burst |
| mem_wdata | output | DW | Data of the current beat |
| mem_wbe | output | DW/8 | Byte enables of the current beat |
| mem_last | output | 1 | Current beat is the burst's last |
| mem_ready | input | 1 | Memory takes the current beat on this edge |

## Verification
`cpu_ready` depends combinationally on the presented address, so the bench reads it a quarter period after it drives a write. A write counts as accepted at the next rising edge. A burst closed by reaching the end of its group shows on `mem_valid` one edge after that acceptance, and a burst closed by the idle timeout shows IDLE_CYC edges after the last acceptance. The bench checks both at the falling edge that follows the edge where the change is due, and checks that `mem_valid` is still low one cycle earlier. Every beat is compared at the falling edge before the rising edge that consumes it, against a burst list built in program order from the grouping rules. Memory readiness is varied so that both stalls and back-to-back drains occur.

// File: rtl/wpost_dual.sv
module wpost_dual #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int BUF_WORDS = 4,
  parameter int IDLE_CYC  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cpu_valid,
  input  logic [AW-1:0]                     cpu_addr,
  input  logic [DW-1:0]                     cpu_wdata,
  input  logic [DW/8-1:0]                   cpu_be,
  output logic                              cpu_ready,
  output logic                              mem_valid,
  output logic [AW-1:0]                     mem_start,
  output logic [$clog2(BUF_WORDS+1)-1:0]    mem_len,
  output logic [DW-1:0]                     mem_wdata,
  output logic [DW/8-1:0]                   mem_wbe,
  output logic                              mem_last,
  input  logic                              mem_ready
);
  localparam int LW = $clog2(BUF_WORDS);
  localparam int CW = $clog2(BUF_WORDS+1);
  localparam int BW = DW/8;
  localparam int IW = $clog2(IDLE_CYC+1);

  logic [DW-1:0] data_q [2][BUF_WORDS];
  logic [BW-1:0] be_q   [2][BUF_WORDS];
  logic [AW-1:0] base_q [2];
  logic [CW-1:0] cnt_q  [2];
  logic [1:0]    closed_q;
  logic          fsel_q, dsel_q;
  logic [LW-1:0] beat_q;
  logic [IW-1:0] idle_q;

  logic          fill_open, need_switch, acc, last_slot, timeout, tgt, mem_fire;
  logic [LW-1:0] wslot;

  assign fill_open   = (cnt_q[fsel_q] != '0) && !closed_q[fsel_q];
  assign need_switch = fill_open && (cpu_addr != base_q[fsel_q] + AW'(cnt_q[fsel_q]));
  assign cpu_ready   = !closed_q[fsel_q] && !(need_switch && closed_q[~fsel_q]);
  assign acc         = cpu_valid && cpu_ready;
  assign tgt         = need_switch ? ~fsel_q : fsel_q;
  assign wslot       = need_switch ? '0 : cnt_q[fsel_q][LW-1:0];
  assign last_slot   = cpu_addr[LW-1:0] == LW'(BUF_WORDS-1);
  assign timeout     = !acc && fill_open && (idle_q == IW'(IDLE_CYC-1));

  assign mem_valid = closed_q[dsel_q];
  assign mem_start = base_q[dsel_q];
  assign mem_len   = cnt_q[dsel_q];
  assign mem_wdata = data_q[dsel_q][beat_q];
  assign mem_wbe   = be_q[dsel_q][beat_q];
  assign mem_last  = (CW'(beat_q) + CW'(1)) == cnt_q[dsel_q];
  assign mem_fire  = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (acc) begin
      data_q[tgt][wslot] <= cpu_wdata;
      be_q[tgt][wslot]   <= cpu_be;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q[0] <= '0;
      base_q[1] <= '0;
      cnt_q[0]  <= '0;
      cnt_q[1]  <= '0;
      closed_q  <= '0;
      fsel_q    <= 1'b0;
      dsel_q    <= 1'b0;
      beat_q    <= '0;
      idle_q    <= '0;
    end else begin
      idle_q <= (acc || !fill_open) ? '0 : idle_q + IW'(1);
      if (acc) begin
        if (wslot == '0) base_q[tgt] <= cpu_addr;
        cnt_q[tgt] <= need_switch ? CW'(1) : cnt_q[fsel_q] + CW'(1);
        if (need_switch) closed_q[fsel_q] <= 1'b1;
        if (last_slot) begin
          closed_q[tgt] <= 1'b1;
          fsel_q        <= ~tgt;
        end else begin
          fsel_q <= tgt;
        end
      end else if (timeout) begin
        closed_q[fsel_q] <= 1'b1;
        fsel_q           <= ~fsel_q;
      end
      if (mem_fire) begin
        if (mem_last) begin
          closed_q[dsel_q] <= 1'b0;
          cnt_q[dsel_q]    <= '0;
          beat_q           <= '0;
          dsel_q           <= ~dsel_q;
        end else begin
          beat_q <= beat_q + LW'(1);
        end
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> cpu_ready && !mem_valid);

  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_len != '0) && (mem_len <= CW'(BUF_WORDS)));

  p_in_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (32'(mem_start[LW-1:0]) + 32'(mem_len)) <= BUF_WORDS);

  p_stall_both_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> (cnt_q[0] != '0) && (cnt_q[1] != '0));

  p_hold_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_start) && $stable(mem_len)
                                && $stable(mem_wdata) && $stable(mem_wbe) && $stable(mem_last));

  p_burst_const_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire && !mem_last |=> mem_valid && $stable(mem_start) && $stable(mem_len));

  p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire && mem_last |=> dsel_q != $past(dsel_q));
endmodule

// File: tb/tb_wpost_dual.sv
module tb_wpost_dual;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 8;

  logic        clk, rst_n, cpu_valid, cpu_ready, mem_valid, mem_last, mem_ready;
  logic [15:0] cpu_addr, mem_start;
  logic [31:0] cpu_wdata, mem_wdata;
  logic [3:0]  cpu_be, mem_wbe;
  logic [2:0]  mem_len;

  wpost_dual #(.AW(16), .DW(32), .BUF_WORDS(4), .IDLE_CYC(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ready(cpu_ready),
    .mem_valid(mem_valid), .mem_start(mem_start), .mem_len(mem_len),
    .mem_wdata(mem_wdata), .mem_wbe(mem_wbe), .mem_last(mem_last), .mem_ready(mem_ready));

  int checks = 0, failures = 0, cycles = 0;
  int exp_start [512];
  int exp_len   [512];
  int exp_d     [2048];
  int exp_be    [2048];
  int nexp = 0, m_open = 0, m_start = 0, m_len = 0;
  int bi = 0, bt = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(0, "watchdog", cycles, 100000);
      finish_run();
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : lfsr[0];
  end

  // beat monitor: R2 contents, R7 order, R9 last flag
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (bi >= nexp) begin
        chk(0, "R7 unexpected burst", int'(mem_start), -1);
      end else begin
        chk(int'(mem_start) == exp_start[bi], "R7 burst start", int'(mem_start), exp_start[bi]);
        chk(int'(mem_len) == exp_len[bi], "R2 burst length", int'(mem_len), exp_len[bi]);
        chk(int'(mem_wdata) == exp_d[bi*4+bt], "R2 beat data", int'(mem_wdata), exp_d[bi*4+bt]);
        chk(int'(mem_wbe) == exp_be[bi*4+bt], "R2 beat enables", int'(mem_wbe), exp_be[bi*4+bt]);
        chk(mem_last == (bt == exp_len[bi]-1), "R9 last flag", int'(mem_last), int'(bt == exp_len[bi]-1));
        if (bt >= exp_len[bi]-1) begin bi++; bt = 0; end
        else bt++;
      end
    end
  end

  task automatic model_close();
    if (m_open != 0) begin
      exp_len[nexp] = m_len;
      nexp++;
      m_open = 0;
    end
  endtask

  task automatic model_push(input int a, input int d, input int b);
    if (m_open != 0 && a != m_start + m_len) model_close();
    if (m_open == 0) begin
      m_open = 1; m_start = a; m_len = 0; exp_start[nexp] = a;
    end
    exp_d[nexp*4+m_len] = d;
    exp_be[nexp*4+m_len] = b;
    m_len++;
    if (a % 4 == 3) model_close();
  endtask

  task automatic drive(input int a, input int d, input int b);
    cpu_valid = 1'b1; cpu_addr = a[15:0]; cpu_wdata = d; cpu_be = b[3:0];
    forever begin
      #2;
      if (cpu_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic wr(input int a, input int d, input int b);
    model_push(a, d, b);
    drive(a, d, b);
  endtask

  task automatic pause_flush();
    model_close();
    repeat (IDLE + 2) @(negedge clk);
    while (bi < nexp) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cpu_valid = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_be = '0; mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R1 ready after reset", int'(cpu_ready), 1);
    chk(mem_valid == 1'b0, "R1 no burst after reset", int'(mem_valid), 0);

    // R8: idle timeout timing
    rdy_mode = 0;
    wr(500, 32'h1111_0000, 4'hF);
    model_close();
    repeat (IDLE - 1) @(negedge clk);
    chk(mem_valid == 1'b0, "R8 still open one cycle early", int'(mem_valid), 0);
    @(negedge clk);
    chk(mem_valid == 1'b1 && mem_start == 16'd500 && mem_len == 3'd1, "R8 timeout flush", int'(mem_valid), 1);
    pause_flush();

    // R3: group end closes buffer, offered the next cycle
    for (int i = 0; i < 4; i++) wr(520 + i, 32'h2000 + i, 4'hF);
    chk(mem_valid == 1'b1 && mem_len == 3'd4 && mem_start == 16'd520, "R3 full group offered", int'(mem_len), 4);
    wr(526, 32'h3000, 4'h3);
    wr(527, 32'h3001, 4'hC);
    chk(mem_valid == 1'b1, "R3 partial group closes at offset 3", int'(mem_valid), 1);
    wr(528, 32'h3002, 4'h1);
    pause_flush();

    // R4: repeated address and jump
    wr(40, 32'hAAAA, 4'hF);
    wr(40, 32'hBBBB, 4'h5);
    wr(90, 32'hCCCC, 4'hA);
    pause_flush();

    // R5, R6: stall only when both buffers hold data
    rdy_mode = 2;
    repeat (2) @(negedge clk);
    wr(100, 32'h100, 4'hF);
    wr(200, 32'h200, 4'hF);
    chk(mem_valid == 1'b1 && mem_start == 16'd100, "R5 second buffer accepted while first waits", int'(mem_start), 100);
    model_push(300, 32'h300, 4'hF);
    cpu_valid = 1'b1; cpu_addr = 16'd300; cpu_wdata = 32'h300; cpu_be = 4'hF;
    #2;
    chk(cpu_ready == 1'b0, "R6 stall with both buffers occupied", int'(cpu_ready), 0);
    @(negedge clk);
    #2;
    chk(cpu_ready == 1'b0 && mem_start == 16'd100, "R6 stall persists, burst held", int'(cpu_ready), 0);
    rdy_mode = 0;
    drive(300, 32'h300, 4'hF);
    pause_flush();

    // sweep: start offset x run length under random memory readiness
    rdy_mode = 1;
    for (int k = 0; k < 4; k++) begin
      for (int n = 1; n <= 6; n++) begin
        for (int i = 0; i < n; i++) begin
          int a;
          a = 1024 + 64 * (k * 8 + n) + k + i;
          wr(a, (k << 16) | (n << 8) | i, ((i + k + n) % 15) + 1);
        end
      end
    end
    pause_flush();
    chk(bi == nexp, "R7 all bursts delivered", bi, nexp);
    finish_run();
  end
endmodule